// File: doc/BRIEF.md
# Store Execute Unit

This block executes the halfword and word store instructions of an integer pipeline. It takes one decoded instruction word, the base-register value and the store-data register value. It adds the sign-extended 16-bit displacement to the base to form the effective byte address, then checks that address against the access size. When the address is aligned, it returns one write request with a word-aligned address, per-byte write enables and lane-replicated write data. When the address is not aligned, it raises a one-cycle misaligned-address exception and issues no request.

Each store opcode has a plain form and an I/O form. The request carries a target-select bit. When the unit is built with a data cache, plain stores go to the cache port and I/O stores go to the memory-mapped bus port, so that they always produce a real bus cycle. When no cache is configured, every store goes to the bus and the I/O forms behave exactly like the plain ones. The input side and the request side each use a valid/ready handshake, with a single registered stage between them.

Top module: `store_exec_unit`

## Requirements
- R1: The effective address is the base operand plus the 16-bit displacement (instruction bits 21:6), sign-extended to 32 bits and added modulo 2^32. The request address is that sum with bits 1:0 cleared.
- R2: A word store (opcode bits 5:0 = 0x15 plain, 0x35 I/O) with an effective address that is a multiple of 4 produces a request with byte enables 4'b1111 and the full store-data operand as write data.
- R3: A halfword store (opcode 0x0d plain, 0x2d I/O) with effective-address bit 0 clear produces byte enables 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. Its write data is the low 16 bits of the store-data operand placed in both halves.
- R4: A word store whose effective address has bits 1:0 not equal to zero pulses the exception output high for one cycle and produces no request.
- R5: A halfword store whose effective-address bit 0 is set pulses the exception output high for one cycle and produces no request.
- R6: With the data cache present (HAS_DCACHE=1), plain stores set the target bit to 0 (cache port) and I/O stores set it to 1 (bus port).
- R7: With no data cache (HAS_DCACHE=0), every store, plain or I/O, sets the target bit to 1.
- R8: While a request is valid and not accepted, the input-ready output is low and the request address, data, byte enables and target bit stay unchanged.
- R9: An accepted instruction with any other opcode produces neither a request nor an exception.
- R10: While reset is low at a clock edge, the request-valid and exception outputs are 0 after that edge.
- R11: A request or an exception appears in the cycle right after the clock edge at which the instruction is accepted (input valid and ready both high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are valid |
| in_ready | output | 1 | Unit can accept an instruction |
| in_instr | input | 32 | Instruction word (A 31:27, B 26:22, displacement 21:6, opcode 5:0) |
| in_base | input | 32 | Base register value |
| in_sdata | input | 32 | Store-data register value |
| req_valid | output | 1 | Write request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_addr | output | 32 | Word-aligned write address |
| req_wdata | output | 32 | Write data, lane-aligned |
| req_be | output | 4 | Byte enables |
| req_to_bus | output | 1 | 1 = bus port, 0 = data-cache port |
| misalign_exc | output | 1 | One-cycle misaligned-address exception |

## Verification
One register stage sits between acceptance and the outputs. A request or an exception is therefore due one clock after the edge at which in_valid and in_ready were both high. The bench drives inputs on the falling edge and samples on the following falling edge, half a cycle after the edge that loads the result. A separate directed test holds req_ready low for two cycles and samples on each of those falling edges. It confirms that the held request stays unchanged and that a new instruction lands exactly one edge after ready returns.

// File: rtl/store_pkg.sv
// Package: shared constants and types for the store execute unit.
// Assumes a 32-bit datapath with a 16-bit displacement field.
package store_pkg;
    localparam int XLEN   = 32;
    localparam int IMM_W  = 16;
    localparam int OPC_W  = 6;
    localparam int LANES  = XLEN / 8;

    localparam logic [OPC_W-1:0] OPC_ST_HALF    = 6'h0d;
    localparam logic [OPC_W-1:0] OPC_ST_HALF_IO = 6'h2d;
    localparam logic [OPC_W-1:0] OPC_ST_WORD    = 6'h15;
    localparam logic [OPC_W-1:0] OPC_ST_WORD_IO = 6'h35;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } st_size_e;

    typedef struct packed {
        st_size_e         size;
        logic             is_io;
        logic [IMM_W-1:0] disp;
    } st_op_t;
endpackage

// File: rtl/store_decode.sv
// Module: store_decode
// Picks the displacement and opcode out of the instruction word and
// classifies it as a halfword store, a word store or not a store.
// Assumes the displacement sits in bits 21:6 and the opcode in bits 5:0;
// the register index fields are resolved upstream.
module store_decode
    import store_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output st_op_t          op
);
    logic [OPC_W-1:0] opc;

    assign opc = instr[OPC_W-1:0];

    // Classify the opcode and extract the displacement.
    always_comb begin
        op.disp  = instr[OPC_W +: IMM_W];
        op.size  = SZ_NONE;
        op.is_io = 1'b0;
        unique case (opc)
            OPC_ST_HALF:    op.size = SZ_HALF;
            OPC_ST_HALF_IO: begin op.size = SZ_HALF; op.is_io = 1'b1; end
            OPC_ST_WORD:    op.size = SZ_WORD;
            OPC_ST_WORD_IO: begin op.size = SZ_WORD; op.is_io = 1'b1; end
            default:        op.size = SZ_NONE;
        endcase
    end
endmodule

// File: rtl/store_addr_gen.sv
// Module: store_addr_gen
// Forms the effective byte address and checks it against the access size.
// Assumes the size code is SZ_NONE for anything that is not a store.
module store_addr_gen
    import store_pkg::*;
(
    input  logic [XLEN-1:0]  base,
    input  logic [IMM_W-1:0] disp,
    input  st_size_e         size,
    output logic [XLEN-1:0]  eff_addr,
    output logic             misaligned
);
    logic [XLEN-1:0] disp_sx;

    assign disp_sx  = {{(XLEN-IMM_W){disp[IMM_W-1]}}, disp};
    assign eff_addr = base + disp_sx;

    // Flag low address bits that do not fit the access size.
    always_comb begin
        unique case (size)
            SZ_HALF: misaligned = eff_addr[0];
            SZ_WORD: misaligned = |eff_addr[1:0];
            default: misaligned = 1'b0;
        endcase
    end
endmodule

// File: rtl/store_lane_fmt.sv
// Module: store_lane_fmt
// Builds byte enables and lane-aligned write data for one store.
// Assumes the address is already known to be aligned for the size.
module store_lane_fmt
    import store_pkg::*;
(
    input  st_size_e         size,
    input  logic             addr_b1,
    input  logic [XLEN-1:0]  sdata,
    output logic [LANES-1:0] be,
    output logic [XLEN-1:0]  wdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int HALF_SEL = (g / 2) % 2;
        localparam int SRC_BYTE = g % 2;
        // Enable a lane for a word, or for the halfword that address bit 1 selects.
        assign be[g] = (size == SZ_WORD) ||
                       ((size == SZ_HALF) && (addr_b1 == HALF_SEL[0]));
        // Word takes its own byte; halfword replicates the low 16 bits.
        assign wdata[8*g +: 8] = (size == SZ_WORD) ? sdata[8*g +: 8]
                                                   : sdata[8*SRC_BYTE +: 8];
    end
endmodule

// File: rtl/store_exec_unit.sv
// Module: store_exec_unit
// Executes halfword and word stores (plain and I/O) and produces one
// registered write request or a misaligned-address exception pulse.
// Assumes the operands arrive with the instruction; HAS_DCACHE selects
// whether plain stores are steered to the cache port.
module store_exec_unit
    import store_pkg::*;
#(
    parameter bit HAS_DCACHE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [XLEN-1:0]  in_instr,
    input  logic [XLEN-1:0]  in_base,
    input  logic [XLEN-1:0]  in_sdata,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [XLEN-1:0]  req_addr,
    output logic [XLEN-1:0]  req_wdata,
    output logic [LANES-1:0] req_be,
    output logic             req_to_bus,
    output logic             misalign_exc
);
    st_op_t           op;
    logic [XLEN-1:0]  eff_addr;
    logic             misaligned;
    logic [LANES-1:0] be_c;
    logic [XLEN-1:0]  wdata_c;
    logic             accept;
    logic             issue;
    logic             to_bus_c;

    store_decode u_dec (
        .instr (in_instr),
        .op    (op)
    );

    store_addr_gen u_agen (
        .base       (in_base),
        .disp       (op.disp),
        .size       (op.size),
        .eff_addr   (eff_addr),
        .misaligned (misaligned)
    );

    store_lane_fmt u_fmt (
        .size    (op.size),
        .addr_b1 (eff_addr[1]),
        .sdata   (in_sdata),
        .be      (be_c),
        .wdata   (wdata_c)
    );

    assign in_ready = !req_valid || req_ready;
    assign accept   = in_valid && in_ready;
    assign issue    = accept && (op.size != SZ_NONE) && !misaligned;

    // Pick the target port: I/O forms, or any store without a cache, go to the bus.
    generate
        if (HAS_DCACHE) begin : g_cache
            assign to_bus_c = op.is_io;
        end else begin : g_nocache
            assign to_bus_c = 1'b1;
        end
    endgenerate

    // Output register control: valid flag and exception pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid    <= 1'b0;
            misalign_exc <= 1'b0;
        end else begin
            misalign_exc <= accept && (op.size != SZ_NONE) && misaligned;
            if (in_ready) begin
                req_valid <= issue;
            end
        end
    end

    // Request payload register, loaded only when a request is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr   <= '0;
            req_wdata  <= '0;
            req_be     <= '0;
            req_to_bus <= 1'b0;
        end else if (issue) begin
            req_addr   <= {eff_addr[XLEN-1:2], 2'b00};
            req_wdata  <= wdata_c;
            req_be     <= be_c;
            req_to_bus <= to_bus_c;
        end
    end

    // R8
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
        $stable(req_wdata) && $stable(req_be) && $stable(req_to_bus)));

    // R8
    ready_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |-> !in_ready);

    // R4
    exc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_exc |-> !req_valid);

    // R2
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_be == 4'b1111 || req_be == 4'b0011 || req_be == 4'b1100));

    // R7
    nocache_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !HAS_DCACHE) |-> req_to_bus);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !req_valid) |=> (!req_valid && !misalign_exc));
endmodule

// File: tb/test_store_exec_unit.sv
module test_store_exec_unit;
    typedef struct packed {
        logic [5:0]  opc;
        logic [31:0] base;
        logic [15:0] disp;
        logic [31:0] sdata;
        logic        e_valid;
        logic        e_exc;
        logic [31:0] e_addr;
        logic [31:0] e_data;
        logic [3:0]  e_be;
        logic        e_bus_c;
        logic        e_bus_nc;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{6'h15, 32'h0000_1000, 16'h0010, 32'hDEAD_BEEF, 1'b1, 1'b0, 32'h0000_1010, 32'hDEAD_BEEF, 4'b1111, 1'b0, 1'b1},
        '{6'h35, 32'h0000_2000, 16'hFFFC, 32'h1234_5678, 1'b1, 1'b0, 32'h0000_1FFC, 32'h1234_5678, 4'b1111, 1'b1, 1'b1},
        '{6'h0d, 32'h0000_3000, 16'h0002, 32'hAAAA_5555, 1'b1, 1'b0, 32'h0000_3000, 32'h5555_5555, 4'b1100, 1'b0, 1'b1},
        '{6'h2d, 32'h0000_4001, 16'hFFFF, 32'h0000_BEEF, 1'b1, 1'b0, 32'h0000_4000, 32'hBEEF_BEEF, 4'b0011, 1'b1, 1'b1},
        '{6'h15, 32'h0000_5000, 16'h0002, 32'h1111_1111, 1'b0, 1'b1, 32'h0,         32'h0,         4'b0000, 1'b0, 1'b0},
        '{6'h0d, 32'h0000_6000, 16'h0001, 32'h2222_2222, 1'b0, 1'b1, 32'h0,         32'h0,         4'b0000, 1'b0, 1'b0},
        '{6'h35, 32'h0000_7003, 16'h0001, 32'h0BAD_F00D, 1'b1, 1'b0, 32'h0000_7004, 32'h0BAD_F00D, 4'b1111, 1'b1, 1'b1},
        '{6'h04, 32'h0000_8000, 16'h0001, 32'h3333_3333, 1'b0, 1'b0, 32'h0,         32'h0,         4'b0000, 1'b0, 1'b0},
        '{6'h2d, 32'h0000_9000, 16'h0003, 32'h4444_4444, 1'b0, 1'b1, 32'h0,         32'h0,         4'b0000, 1'b0, 1'b0},
        '{6'h15, 32'hFFFF_FFFC, 16'h0008, 32'hCAFE_F00D, 1'b1, 1'b0, 32'h0000_0004, 32'hCAFE_F00D, 4'b1111, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_instr, in_base, in_sdata;
    logic        req_ready;
    logic        in_ready, req_valid, req_to_bus, misalign_exc;
    logic [31:0] req_addr, req_wdata;
    logic [3:0]  req_be;
    logic        nc_in_ready, nc_req_valid, nc_req_to_bus, nc_misalign_exc;
    logic [31:0] nc_req_addr, nc_req_wdata;
    logic [3:0]  nc_req_be;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    store_exec_unit #(.HAS_DCACHE(1'b1)) i_store_exec_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .in_base(in_base), .in_sdata(in_sdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_to_bus(req_to_bus),
        .misalign_exc(misalign_exc)
    );

    store_exec_unit #(.HAS_DCACHE(1'b0)) i_store_exec_unit_nc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(nc_in_ready),
        .in_instr(in_instr), .in_base(in_base), .in_sdata(in_sdata),
        .req_valid(nc_req_valid), .req_ready(req_ready), .req_addr(nc_req_addr),
        .req_wdata(nc_req_wdata), .req_be(nc_req_be), .req_to_bus(nc_req_to_bus),
        .misalign_exc(nc_misalign_exc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] opc, input logic [31:0] b,
                         input logic [15:0] d, input logic [31:0] s);
        in_valid = 1'b1;
        in_instr = {5'd3, 5'd7, d, opc};
        in_base  = b;
        in_sdata = s;
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_instr = '0; in_base = '0;
        in_sdata = '0; req_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10 req_valid", {31'b0, req_valid}, 32'd0);
        chk("R10 exc", {31'b0, misalign_exc}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1..R7, R9, R11
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].opc, VEC[i].base, VEC[i].disp, VEC[i].sdata);
            @(negedge clk);
            in_valid = 1'b0;
            // R11: result due one edge after acceptance
            chk("R11/R9 req_valid", {31'b0, req_valid}, {31'b0, VEC[i].e_valid});
            chk("R4/R5 exc", {31'b0, misalign_exc}, {31'b0, VEC[i].e_exc});
            chk("R7 nc exc", {31'b0, nc_misalign_exc}, {31'b0, VEC[i].e_exc});
            if (VEC[i].e_valid) begin
                chk("R1 addr", req_addr, VEC[i].e_addr);
                chk("R2/R3 data", req_wdata, VEC[i].e_data);
                chk("R2/R3 be", {28'b0, req_be}, {28'b0, VEC[i].e_be});
                chk("R6 target", {31'b0, req_to_bus}, {31'b0, VEC[i].e_bus_c});
                chk("R7 nc target", {31'b0, nc_req_to_bus}, {31'b0, VEC[i].e_bus_nc});
                chk("R7 nc addr", nc_req_addr, VEC[i].e_addr);
            end
            @(negedge clk);
            // R4: exception is a single-cycle pulse
            chk("R4 exc pulse ends", {31'b0, misalign_exc}, 32'd0);
            chk("R9 idle", {31'b0, req_valid}, 32'd0);
        end

        // R8: back-pressure holds the request
        req_ready = 1'b0;
        drive(VEC[0].opc, VEC[0].base, VEC[0].disp, VEC[0].sdata);
        @(negedge clk);
        drive(VEC[2].opc, VEC[2].base, VEC[2].disp, VEC[2].sdata);
        chk("R8 in_ready low", {31'b0, in_ready}, 32'd0);
        @(negedge clk);
        chk("R8 held valid", {31'b0, req_valid}, 32'd1);
        chk("R8 held addr", req_addr, VEC[0].e_addr);
        chk("R8 held data", req_wdata, VEC[0].e_data);
        @(negedge clk);
        chk("R8 held be", {28'b0, req_be}, 32'hF);
        req_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8/R11 next addr", req_addr, VEC[2].e_addr);
        chk("R8/R11 next be", {28'b0, req_be}, {28'b0, VEC[2].e_be});
        @(negedge clk);

        // R10: reset with a pending request
        req_ready = 1'b0;
        drive(VEC[1].opc, VEC[1].base, VEC[1].disp, VEC[1].sdata);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 mid-run clear", {31'b0, req_valid}, 32'd0);
        rst_n = 1'b1;
        req_ready = 1'b1;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule